// File: doc/BRIEF.md
# Bus Access Violation Flag Controller

This block keeps a record of two kinds of bus-master access violation: instruction fetch and data write. Violation strobes come in from outside, each with the address of the faulting access. For each kind the block holds a sticky flag, the address captured when the flag was raised, and an interrupt enable. A single interrupt output pulses when an enabled flag is newly raised.

Software reaches the block through a simple register port with word offsets. Reads are combinational from the current state. Writes are taken on the clock edge. Software can raise a flag through a write-1-to-set alias and lower it through a write-1-to-clear alias. Both aliases always read as zero. A write-permission input must be high for writes to the set alias, the clear alias and the enable register to take effect. Checking accesses against memory-region rules is left to the logic that drives the strobes.

Top module: `bus_viol_flag_ctrl`

## Requirements
- R1: Register word offsets are 0x20 status flags, 0x22 set alias, 0x24 clear alias, 0x26 interrupt enable, 0x28 captured fetch address and 0x2A captured write address. A read of any other offset returns 0.
- R2: In the flag, set, clear and enable registers, bit 0 is the fetch kind and bit 1 is the write kind. Bits 31 to 2 read as 0.
- R3: A hardware strobe (fetch_viol or write_viol) high at a clock edge sets the matching flag. The flag then stays 1 until a clear. Writes to the flag register at 0x20 have no effect.
- R4: Writing 1 to a bit of the set alias sets the matching flag on that edge. A 0 bit does nothing, and the set alias reads 0.
- R5: Writing 1 to a bit of the clear alias clears the matching flag on that edge. A 0 bit does nothing, and the clear alias reads 0.
- R6: The enable register is read/write. Bit 0 enables the fetch interrupt and bit 1 enables the write interrupt.
- R7: A captured address loads the strobe address only on the edge where its flag goes from 0 to 1 because of a hardware strobe. It holds while the flag is 1. A set-alias raise without a strobe leaves it unchanged, and a clear does not change it.
- R8: Writes to the set alias, clear alias and enable register are ignored while wr_permit is 0.
- R9: After reset, all flags, enables, captured addresses and irq are 0.
- R10: If a set (hardware strobe or set-alias bit) and a clear of the same bit happen on the same edge, the flag ends at 1.
- R11: irq is high for exactly the one cycle after an edge on which an enabled flag goes from 0 to 1, whether a strobe or a set-alias write caused it. A flag that is already 1, or whose enable is 0, raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| wr_permit | input | 1 | Permission for writes to the set, clear and enable registers |
| fetch_viol | input | 1 | Fetch violation strobe |
| fetch_addr | input | 32 | Address of the faulting fetch |
| write_viol | input | 1 | Write violation strobe |
| write_addr | input | 32 | Address of the faulting write |
| irq | output | 1 | Interrupt pulse |

## Verification
Single strobes on each kind check that a flag is raised and its address captured. A repeated strobe while the flag is already up tells a first-event capture apart from an overwriting one. It also shows whether irq is edge-based or level-based. Set-alias, clear-alias and enable writes are each tried with wr_permit low and then high, which separates the gating from the write decode. A strobe on the same edge as a clear of the same bit, and strobes with the enable off, pin down the priority between set and clear and the masking of the interrupt.

// File: rtl/bvf_pkg.sv
package bvf_pkg;
  localparam int DATA_W   = 32;
  localparam int NKIND    = 2;
  localparam int K_FETCH  = 0;
  localparam int K_WRITE  = 1;

  localparam int OFS_FLAG  = 'h20;
  localparam int OFS_SET   = 'h22;
  localparam int OFS_CLR   = 'h24;
  localparam int OFS_EN    = 'h26;
  localparam int OFS_FADDR = 'h28;
  localparam int OFS_WADDR = 'h2A;

  function automatic logic flag_next(input logic cur, input logic set_req, input logic clr_req);
    return set_req | (cur & ~clr_req);
  endfunction

  function automatic logic flag_rise(input logic cur, input logic set_req);
    return set_req & ~cur;
  endfunction

  function automatic logic any_enabled(input logic [NKIND-1:0] ev, input logic [NKIND-1:0] en);
    return |(ev & en);
  endfunction
endpackage

// File: rtl/bvf_decode.sv
module bvf_decode
  import bvf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NK     = NKIND
) (
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              wr_permit,
  output logic [NK-1:0]     sw_set,
  output logic [NK-1:0]     sw_clr,
  output logic              en_load,
  output logic [NK-1:0]     en_val
);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_EN);

  logic wr_ok;

  always_comb begin
    wr_ok   = reg_wr & wr_permit;
    sw_set  = (wr_ok && reg_addr == A_SET) ? reg_wdata[NK-1:0] : '0;
    sw_clr  = (wr_ok && reg_addr == A_CLR) ? reg_wdata[NK-1:0] : '0;
    en_load = wr_ok && reg_addr == A_EN;
    en_val  = reg_wdata[NK-1:0];
  end
endmodule

// File: rtl/bvf_kind_slice.sv
module bvf_kind_slice
  import bvf_pkg::*;
#(
  parameter int CAP_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_strobe,
  input  logic [CAP_W-1:0] hw_addr,
  input  logic             sw_set,
  input  logic             sw_clr,
  output logic             flag,
  output logic [CAP_W-1:0] cap_addr,
  output logic             rise
);
  logic set_req;
  logic load_addr;

  always_comb begin
    set_req   = hw_strobe | sw_set;
    rise      = flag_rise(flag, set_req);
    load_addr = hw_strobe & ~flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      cap_addr <= '0;
    end else begin
      flag <= flag_next(flag, set_req, sw_clr);
      if (load_addr) cap_addr <= hw_addr;
    end
  end

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !sw_clr) |=> flag);
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_strobe || sw_set) |=> flag);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr && !hw_strobe && !sw_set) |=> !flag);
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> $stable(cap_addr));
  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && hw_strobe) |=> (cap_addr == $past(hw_addr)));
endmodule

// File: rtl/bvf_irq_gen.sv
module bvf_irq_gen
  import bvf_pkg::*;
#(
  parameter int NK = NKIND
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_load,
  input  logic [NK-1:0] en_val,
  input  logic [NK-1:0] rise,
  input  logic [NK-1:0] flags,
  output logic [NK-1:0] en_q,
  output logic          irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      irq  <= 1'b0;
    end else begin
      if (en_load) en_q <= en_val;
      irq <= any_enabled(rise, en_q);
    end
  end

  p_en_protect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_load |=> $stable(en_q));
  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((flags & $past(en_q)) != '0));
  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rise == '0) |=> !irq);
endmodule

// File: rtl/bvf_rdmux.sv
module bvf_rdmux
  import bvf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NK     = NKIND,
  parameter int CAP_W  = 32
) (
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [NK-1:0]       flags,
  input  logic [NK-1:0]       en_q,
  input  logic [NK*CAP_W-1:0] caps,
  output logic [DATA_W-1:0]   reg_rdata
);
  localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(OFS_FLAG);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_FADDR = ADDR_W'(OFS_FADDR);
  localparam logic [ADDR_W-1:0] A_WADDR = ADDR_W'(OFS_WADDR);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_FLAG:  reg_rdata = DATA_W'(flags);
      A_EN:    reg_rdata = DATA_W'(en_q);
      A_FADDR: reg_rdata = DATA_W'(caps[K_FETCH*CAP_W +: CAP_W]);
      A_WADDR: reg_rdata = DATA_W'(caps[K_WRITE*CAP_W +: CAP_W]);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bus_viol_flag_ctrl.sv
module bus_viol_flag_ctrl
  import bvf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CAP_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              wr_permit,
  input  logic              fetch_viol,
  input  logic [CAP_W-1:0]  fetch_addr,
  input  logic              write_viol,
  input  logic [CAP_W-1:0]  write_addr,
  output logic              irq
);
  localparam int NK = NKIND;
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_CLR);

  logic [NK-1:0]       sw_set, sw_clr, en_val, en_q, flags, rise, hw_strobe;
  logic [NK*CAP_W-1:0] hw_addr, caps;
  logic                en_load;

  assign hw_strobe[K_FETCH] = fetch_viol;
  assign hw_strobe[K_WRITE] = write_viol;
  assign hw_addr[K_FETCH*CAP_W +: CAP_W] = fetch_addr;
  assign hw_addr[K_WRITE*CAP_W +: CAP_W] = write_addr;

  bvf_decode #(.ADDR_W(ADDR_W), .NK(NK)) u_dec (
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .wr_permit(wr_permit), .sw_set(sw_set), .sw_clr(sw_clr),
    .en_load(en_load), .en_val(en_val)
  );

  for (genvar k = 0; k < NK; k++) begin : g_kind
    bvf_kind_slice #(.CAP_W(CAP_W)) u_slice (
      .clk(clk), .rst_n(rst_n),
      .hw_strobe(hw_strobe[k]), .hw_addr(hw_addr[k*CAP_W +: CAP_W]),
      .sw_set(sw_set[k]), .sw_clr(sw_clr[k]),
      .flag(flags[k]), .cap_addr(caps[k*CAP_W +: CAP_W]), .rise(rise[k])
    );
  end

  bvf_irq_gen #(.NK(NK)) u_irq (
    .clk(clk), .rst_n(rst_n), .en_load(en_load), .en_val(en_val),
    .rise(rise), .flags(flags), .en_q(en_q), .irq(irq)
  );

  bvf_rdmux #(.ADDR_W(ADDR_W), .NK(NK), .CAP_W(CAP_W)) u_rd (
    .reg_addr(reg_addr), .flags(flags), .en_q(en_q), .caps(caps),
    .reg_rdata(reg_rdata)
  );

  p_alias_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_SET || reg_addr == A_CLR) |-> (reg_rdata == '0));
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFS_FLAG) || reg_addr == ADDR_W'(OFS_EN)) |-> (reg_rdata[DATA_W-1:NK] == '0));
  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_permit && !fetch_viol && !write_viol) |=> ($past(flags) == flags));
endmodule

// File: tb/bus_viol_flag_ctrl_tb_top.sv
module bus_viol_flag_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } chk_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic        wr_permit = 1'b0;
  logic        fetch_viol = 1'b0, write_viol = 1'b0;
  logic [31:0] fetch_addr = '0, write_addr = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  chk_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  logic [1:0]  m_flag = '0, m_en = '0;
  logic [31:0] m_cap0 = '0, m_cap1 = '0;
  logic        m_irq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_viol_flag_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_permit(wr_permit),
    .fetch_viol(fetch_viol), .fetch_addr(fetch_addr),
    .write_viol(write_viol), .write_addr(write_addr), .irq(irq)
  );

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h20:   return {30'd0, m_flag};
      8'h26:   return {30'd0, m_en};
      8'h28:   return m_cap0;
      8'h2A:   return m_cap1;
      default: return 32'd0;
    endcase
  endfunction

  // one cycle: drive, queue expected read and irq, advance the model
  task automatic step(input string tag, input logic wr, input logic [7:0] a,
                      input logic [31:0] d, input logic p, input logic [1:0] hv,
                      input logic [31:0] a0, input logic [31:0] a1);
    logic [1:0] setq, clrq, rise;
    chk_t c;
    @(posedge clk); #1;
    reg_wr = wr; reg_addr = a; reg_wdata = d; wr_permit = p;
    fetch_viol = hv[0]; write_viol = hv[1]; fetch_addr = a0; write_addr = a1;
    c.is_irq = 0; c.exp = m_read(a); c.tag = tag; q.push_back(c);
    c.is_irq = 1; c.exp = {31'd0, m_irq}; q.push_back(c);
    setq = hv | ((wr && p && a == 8'h22) ? d[1:0] : 2'b00);
    clrq = (wr && p && a == 8'h24) ? d[1:0] : 2'b00;
    rise = setq & ~m_flag;
    m_irq = |(rise & m_en);
    if (rise[0] && hv[0]) m_cap0 = a0;
    if (rise[1] && hv[1]) m_cap1 = a1;
    m_flag = setq | (m_flag & ~clrq);
    if (wr && p && a == 8'h26) m_en = d[1:0];
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    step(tag, 1'b0, a, 32'd0, 1'b0, 2'b00, 32'd0, 32'd0);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      chk_t c;
      logic [31:0] act;
      c = q.pop_front();
      act = c.is_irq ? {31'd0, irq} : reg_rdata;
      total++;
      if (act !== c.exp) begin
        bad++;
        $display("FAIL %s %s act=%h exp=%h", c.tag, c.is_irq ? "irq" : "rdata", act, c.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9 reset values, R1 reserved offsets
    rd("R9 flags", 8'h20); rd("R9 en", 8'h26); rd("R9 cap0", 8'h28);
    rd("R9 cap1", 8'h2A); rd("R1 rsv21", 8'h21); rd("R1 rsv30", 8'h30);
    // R8 enable gated
    step("R8 en nopermit", 1, 8'h26, 32'h3, 0, 2'b00, 0, 0);
    rd("R8 en read", 8'h26);
    // R6 R2 enable write, upper bits read 0
    step("R6 en write", 1, 8'h26, 32'hFFFF_FFFF, 1, 2'b00, 0, 0);
    rd("R2 en upper", 8'h26);
    // R3 R7 R11 fetch strobe
    step("R3 fetch", 0, 8'h20, 0, 0, 2'b01, 32'h1000_0040, 32'hDEAD_0000);
    rd("R11 R3 flag", 8'h20);
    rd("R7 cap0", 8'h28);
    // R7 R11 repeat strobe: no overwrite, no pulse
    step("R7 again", 0, 8'h28, 0, 0, 2'b01, 32'h2222_3333, 0);
    rd("R7 hold", 8'h28);
    // R3 flag register write ignored
    step("R3 flagwr", 1, 8'h20, 32'h0, 1, 2'b00, 0, 0);
    rd("R3 flag kept", 8'h20);
    // R8 clear and set gated
    step("R8 clr nopermit", 1, 8'h24, 32'h3, 0, 2'b00, 0, 0);
    step("R8 set nopermit", 1, 8'h22, 32'h2, 0, 2'b00, 0, 0);
    rd("R8 flags", 8'h20);
    // R5 clear fetch
    step("R5 clear", 1, 8'h24, 32'h1, 1, 2'b00, 0, 0);
    rd("R5 flags", 8'h20); rd("R5 alias", 8'h24); rd("R7 cap0 after clr", 8'h28);
    // R4 software set write kind
    step("R4 set", 1, 8'h22, 32'h2, 1, 2'b00, 0, 0);
    rd("R4 R11 flags", 8'h20); rd("R4 alias", 8'h22); rd("R7 cap1 swset", 8'h2A);
    // R11 disabled: no pulse, capture still happens
    step("R11 en off", 1, 8'h26, 32'h0, 1, 2'b00, 0, 0);
    step("R5 clr all", 1, 8'h24, 32'h3, 1, 2'b00, 0, 0);
    step("R11 masked", 0, 8'h20, 0, 0, 2'b10, 0, 32'h0BAD_F00D);
    rd("R11 masked flags", 8'h20); rd("R7 cap1", 8'h2A);
    // R10 set beats clear
    step("R6 en fetch", 1, 8'h26, 32'h1, 1, 2'b00, 0, 0);
    step("R5 clr all2", 1, 8'h24, 32'h3, 1, 2'b00, 0, 0);
    step("R10 race", 1, 8'h24, 32'h1, 1, 2'b01, 32'h4444_5555, 0);
    rd("R10 flags", 8'h20); rd("R10 cap0", 8'h28);
    // R11 both strobes after clear, only fetch enabled
    step("R5 clr all3", 1, 8'h24, 32'h3, 1, 2'b00, 0, 0);
    step("R11 both", 0, 8'h20, 0, 0, 2'b11, 32'h6666_0000, 32'h7777_0000);
    rd("R11 both flags", 8'h20); rd("R7 both cap0", 8'h28); rd("R7 both cap1", 8'h2A);
    rd("R11 tail", 8'h20);
    @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule